// File: doc/BRIEF.md
# Misaligned Access Splitting Unit

This block sits between a load/store requester and a memory port that is organised in whole words (32 bits by default). The requester issues byte-addressed reads and writes of 1, 2 or 4 bytes. An access of `s` bytes at byte address `A` is aligned when `A mod s` is 0.

Any request whose bytes all fall inside one word goes out as a single word transaction. A request whose bytes run past the end of a word becomes two aligned word transactions: the first at the word holding `A`, the second at the next word. This happens for a 4-byte access at a non-multiple-of-4 address, and for a 2-byte access at byte offset 3. A 1-byte access never crosses a word.

For writes, the unit places the requester's bytes on the correct lanes and gives each transaction a byte-enable mask. For reads, it collects the lanes from the one or two returned words and assembles a right-justified, zero-extended result. Both sides use a valid/ready handshake. Read data from memory arrives exactly one cycle after the memory accepts a read. The requester receives one completion pulse per request, however many transactions the request needed.

Top module: `unaligned_split_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_valid` is 0 and `rsp_done` is 0.
- R2: A request with byte offset `o = A mod 4` and `s` bytes where `o + s <= 4` produces exactly one memory transaction. That transaction has `mem_addr` equal to `A` with bits [1:0] cleared. A 1-byte request never produces more than one transaction.
- R3: A request with `o + s > 4` produces exactly two transactions. The first is at `A` with bits [1:0] cleared and the second is at that address plus 4. The second is presented only after the first has been accepted.
- R4: Let `span = ((1 << s) - 1) << o`, an 8-bit value. The first transaction carries `mem_be = span[3:0]` and the second carries `span[7:4]`, so the enabled lanes total exactly `s`. Reads carry the same masks as writes.
- R5: On every write transaction, byte lane `j` of `mem_wdata` (bits `8j+7:8j`) holds byte `(j - o) mod 4` of `req_wdata`.
- R6: When a read completes, byte `i` of `rsp_rdata` is memory byte `A + i` for `i < s`. All bytes from `s` upward are 0.
- R7: `req_ready` stays 0 from the cycle after a request is accepted until the cycle in which `rsp_done` pulses. `rsp_done` is high for exactly one cycle per request, and `req_ready` is 1 in that cycle.
- R8: While `mem_valid` is high and `mem_ready` is low, the transaction on `mem_addr`, `mem_be` and `mem_wdata` is held. For a write, `rsp_done` pulses one cycle after its last transaction is accepted. For a read, it pulses two cycles after.
- R9: `req_size` encodes the size: 0 means 1 byte, 1 means 2 bytes, and both 2 and 3 mean 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code (R9) |
| req_addr | input | ADDR_W (16) | Byte address |
| req_wdata | input | DATA_W (32) | Right-justified write bytes |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (32) | Assembled read result, valid with `rsp_done` |
| mem_valid | output | 1 | Memory transaction present |
| mem_ready | input | 1 | Memory accepts the transaction |
| mem_write | output | 1 | Transaction is a write |
| mem_addr | output | ADDR_W (16) | Word-aligned byte address |
| mem_be | output | DATA_W/8 (4) | Byte-lane enables |
| mem_wdata | output | DATA_W (32) | Lane-positioned write data |
| mem_rdata | input | DATA_W (32) | Read data, one cycle after a read is accepted |

## Verification
The bench drives requests and observes results only at falling edges, so it never samples at the edge where they change. It records the cycle in which the last memory transaction of each request is accepted, then requires `rsp_done` exactly one cycle later for writes and two cycles later for reads. It checks that `req_ready` stays low on every cycle in between. A cycle-based ready pattern on the memory side inserts stalls that land between the two halves of a split. Because of this, the address, enable and data of every accepted transaction are captured at acceptance rather than at presentation.

// File: rtl/usp_pkg.sv
package usp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LO   = 2'd1,
      ST_HI   = 2'd2,
      ST_WAIT = 2'd3
   } usp_state_e;

   // size code to byte count: 0 -> 1, 1 -> 2, 2 and 3 -> 4
   function automatic int unsigned size_to_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/usp_lane_map.sv
module usp_lane_map #(
   parameter int LANES = 4,
   parameter int OFS_W = 2,
   parameter int CNT_W = 3
) (
   input  logic [OFS_W-1:0] offset,
   input  logic [CNT_W-1:0] nbytes,
   output logic [LANES-1:0] be_lo,
   output logic [LANES-1:0] be_hi,
   output logic             split
);

   localparam int SPAN_W = 2 * LANES;

   logic [LANES-1:0]  base_mask;
   logic [SPAN_W-1:0] span;

   for (genvar i = 0; i < LANES; i++) begin : g_base
      assign base_mask[i] = (CNT_W'(i) < nbytes);
   end

   assign span  = {{LANES{1'b0}}, base_mask} << offset;
   assign be_lo = span[LANES-1:0];
   assign be_hi = span[SPAN_W-1:LANES];
   assign split = |be_hi;

endmodule

// File: rtl/usp_byte_rotate.sv
module usp_byte_rotate #(
   parameter int LANES    = 4,
   parameter int OFS_W    = 2,
   parameter bit ROT_LEFT = 1'b1
) (
   input  logic [8*LANES-1:0] din,
   input  logic [OFS_W-1:0]   amt,
   output logic [8*LANES-1:0] dout
);

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [OFS_W-1:0] src;
      if (ROT_LEFT) begin : g_left
         assign src = OFS_W'(j) - amt;
      end else begin : g_right
         assign src = OFS_W'(j) + amt;
      end
      assign dout[8*j +: 8] = din[8*src +: 8];
   end

endmodule

// File: rtl/usp_read_merge.sv
module usp_read_merge #(
   parameter int LANES = 4,
   parameter int OFS_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               capture,
   input  logic [8*LANES-1:0] word_in,
   input  logic [OFS_W-1:0]   offset,
   input  logic [LANES-1:0]   lane_en,
   output logic [8*LANES-1:0] result
);

   localparam int DW = 8 * LANES;

   logic [DW-1:0] aligned;
   logic [DW-1:0] keep;
   logic [DW-1:0] acc_q;

   usp_byte_rotate #(
      .LANES   (LANES),
      .OFS_W   (OFS_W),
      .ROT_LEFT(1'b0)
   ) u_rot (
      .din (word_in),
      .amt (offset),
      .dout(aligned)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_keep
      logic [OFS_W-1:0] src;
      assign src           = OFS_W'(i) + offset;
      assign keep[8*i +: 8] = {8{lane_en[src]}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clear) begin
         acc_q <= '0;
      end else if (capture) begin
         acc_q <= acc_q | (aligned & keep);
      end
   end

   assign result = acc_q;

   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (result == '0)); // R6

endmodule

// File: rtl/unaligned_split_unit.sv
module unaligned_split_unit #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   import usp_pkg::*;

   localparam int LANES  = DATA_W / 8;
   localparam int OFS_W  = $clog2(LANES);
   localparam int CNT_W  = $clog2(LANES + 1);
   localparam int WORD_W = ADDR_W - OFS_W;

   if ((DATA_W % 8) != 0 || LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power-of-two multiple of 8 of at least 32");
   end
   if (ADDR_W <= OFS_W + 1) begin : g_bad_addr
      $error("ADDR_W too small for the word size");
   end

   usp_state_e        state_q, state_d;
   logic              wr_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [WORD_W-1:0] word_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  be_lo_q, be_hi_q;
   logic              split_q;
   logic              done_q, done_d;
   logic              rd_pend_q, rd_hi_q;

   logic              req_fire, mem_fire;
   logic [CNT_W-1:0]  req_nbytes;
   logic [OFS_W-1:0]  req_ofs;
   logic [LANES-1:0]  dec_be_lo, dec_be_hi;
   logic              dec_split;
   logic [DATA_W-1:0] wdata_rot;

   assign req_ready  = (state_q == ST_IDLE);
   assign req_fire   = req_valid && req_ready;
   assign mem_valid  = (state_q == ST_LO) || (state_q == ST_HI);
   assign mem_fire   = mem_valid && mem_ready;
   assign req_nbytes = CNT_W'(size_to_bytes(req_size));
   assign req_ofs    = req_addr[OFS_W-1:0];

   usp_lane_map #(
      .LANES(LANES),
      .OFS_W(OFS_W),
      .CNT_W(CNT_W)
   ) u_map (
      .offset(req_ofs),
      .nbytes(req_nbytes),
      .be_lo (dec_be_lo),
      .be_hi (dec_be_hi),
      .split (dec_split)
   );

   usp_byte_rotate #(
      .LANES   (LANES),
      .OFS_W   (OFS_W),
      .ROT_LEFT(1'b1)
   ) u_wrot (
      .din (req_wdata),
      .amt (req_ofs),
      .dout(wdata_rot)
   );

   always_comb begin
      state_d = state_q;
      done_d  = 1'b0;
      unique case (state_q)
         ST_IDLE: if (req_valid) state_d = ST_LO;
         ST_LO: begin
            if (mem_ready) begin
               if (split_q) begin
                  state_d = ST_HI;
               end else if (wr_q) begin
                  state_d = ST_IDLE;
                  done_d  = 1'b1;
               end else begin
                  state_d = ST_WAIT;
               end
            end
         end
         ST_HI: begin
            if (mem_ready) begin
               if (wr_q) begin
                  state_d = ST_IDLE;
                  done_d  = 1'b1;
               end else begin
                  state_d = ST_WAIT;
               end
            end
         end
         ST_WAIT: begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         done_q    <= 1'b0;
         rd_pend_q <= 1'b0;
         rd_hi_q   <= 1'b0;
      end else begin
         state_q   <= state_d;
         done_q    <= done_d;
         rd_pend_q <= mem_fire && !wr_q;
         rd_hi_q   <= (state_q == ST_HI);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         ofs_q   <= '0;
         word_q  <= '0;
         wdata_q <= '0;
         be_lo_q <= '0;
         be_hi_q <= '0;
         split_q <= 1'b0;
      end else if (req_fire) begin
         wr_q    <= req_write;
         ofs_q   <= req_ofs;
         word_q  <= req_addr[ADDR_W-1:OFS_W];
         wdata_q <= wdata_rot;
         be_lo_q <= dec_be_lo;
         be_hi_q <= dec_be_hi;
         split_q <= dec_split;
      end
   end

   assign mem_write = wr_q;
   assign mem_addr  = {word_q + WORD_W'(state_q == ST_HI), {OFS_W{1'b0}}};
   assign mem_be    = (state_q == ST_HI) ? be_hi_q : be_lo_q;
   assign mem_wdata = wdata_q;
   assign rsp_done  = done_q;

   usp_read_merge #(
      .LANES(LANES),
      .OFS_W(OFS_W)
   ) u_merge (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (req_fire),
      .capture(rd_pend_q),
      .word_in(mem_rdata),
      .offset (ofs_q),
      .lane_en(rd_hi_q ? be_hi_q : be_lo_q),
      .result (rsp_rdata)
   );

   AST_BYTE_NEVER_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && req_size == 2'd0) |=> !split_q); // R2

   AST_SECOND_NEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_fire && state_q == ST_LO && split_q) |=>
         (mem_valid && mem_addr == $past(mem_addr) + ADDR_W'(LANES))); // R3

   AST_BE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      req_fire |=> (($countones(be_lo_q) + $countones(be_hi_q)) == int'($past(req_nbytes)))); // R4

   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R7

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=>
         (mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata))); // R8

   AST_WRITE_DONE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_fire && mem_write && !(state_q == ST_LO && split_q)) |=> rsp_done); // R8

endmodule

// File: tb/unaligned_split_unit_test.sv
module unaligned_split_unit_test;

   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [1:0]    req_size = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_done;
   logic [DW-1:0] rsp_rdata;
   logic          mem_valid;
   logic          mem_ready;
   logic          mem_write;
   logic [AW-1:0] mem_addr;
   logic [3:0]    mem_be;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata;

   always #5 clk = ~clk;

   unaligned_split_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   logic [3:0] stall_ctr;
   logic [7:0] mem_b [0:255];
   logic [7:0] ref_b [0:255];

   int            n_fire;
   int            last_fire_cyc;
   logic [AW-1:0] f_addr [0:1];
   logic [3:0]    f_be   [0:1];
   logic [DW-1:0] f_wd   [0:1];
   logic          f_wr   [0:1];

   initial begin
      stall_ctr = '0;
      mem_ready = 1'b0;
      mem_rdata = '0;
      n_fire    = 0;
      last_fire_cyc = 0;
      for (int k = 0; k < 256; k++) begin
         mem_b[k] = 8'(k * 7 + 3);
         ref_b[k] = 8'(k * 7 + 3);
      end
   end

   // memory model: ready pattern with stalls, one-cycle read latency
   always @(posedge clk) begin
      cyc       <= cyc + 1;
      stall_ctr <= stall_ctr + 4'd1;
      mem_ready <= (stall_ctr % 4'd3) != 4'd2;
      if (mem_valid && mem_ready) begin
         if (mem_write) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem_b[{mem_addr[7:2], 2'(b)}] <= mem_wdata[8*b +: 8];
         end else begin
            mem_rdata <= {mem_b[{mem_addr[7:2], 2'd3}], mem_b[{mem_addr[7:2], 2'd2}],
                          mem_b[{mem_addr[7:2], 2'd1}], mem_b[{mem_addr[7:2], 2'd0}]};
         end
      end else begin
         mem_rdata <= 32'hDEAD_BEEF;
      end
   end

   // transaction monitor, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && mem_valid && mem_ready) begin
         if (n_fire < 2) begin
            f_addr[n_fire] = mem_addr;
            f_be[n_fire]   = mem_be;
            f_wd[n_fire]   = mem_wdata;
            f_wr[n_fire]   = mem_write;
         end
         n_fire        = n_fire + 1;
         last_fire_cyc = cyc;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic do_req(input bit wr, input logic [1:0] sz, input logic [AW-1:0] a,
                         input logic [31:0] wd);
      int s, o, exp_n, waited, done_cyc;
      logic [7:0]    span;
      logic [31:0]   exp_rd, exp_wd;
      logic [AW-1:0] base;
      bit busy_ok;
      s      = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      o      = int'(a[1:0]);
      span   = 8'(((1 << s) - 1) << o);
      exp_n  = (span[7:4] != 4'd0) ? 2 : 1;
      base   = {a[AW-1:2], 2'b00};
      exp_rd = '0;
      for (int i = 0; i < s; i++) exp_rd[8*i +: 8] = ref_b[8'(a + AW'(i))];
      for (int j = 0; j < 4; j++) exp_wd[8*j +: 8] = wd[8*((j - o) & 3) +: 8];

      @(negedge clk);
      n_fire    = 0;
      req_valid = 1'b1;
      req_write = wr;
      req_size  = sz;
      req_addr  = a;
      req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      waited  = 0;
      busy_ok = 1'b1;
      while (!rsp_done && waited < 60) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         waited++;
      end
      done_cyc = cyc;
      chk(rsp_done, "R7", "done pulse seen", 32'(rsp_done), 32'd1);
      chk(busy_ok, "R7", "ready low while busy", 32'(busy_ok), 32'd1);
      chk(req_ready, "R7", "ready with done", 32'(req_ready), 32'd1);
      chk(n_fire == exp_n, (exp_n == 1) ? "R2" : "R3", "transaction count",
          32'(n_fire), 32'(exp_n));
      if (sz == 2'd3) chk(n_fire == exp_n, "R9", "size code 3 as 4 bytes", 32'(n_fire), 32'(exp_n));
      chk(f_addr[0] == base, "R2", "first address", 32'(f_addr[0]), 32'(base));
      chk(f_be[0] == span[3:0], "R4", "first enables", 32'(f_be[0]), 32'(span[3:0]));
      chk(f_wr[0] == wr, "R2", "write flag", 32'(f_wr[0]), 32'(wr));
      if (exp_n == 2) begin
         chk(f_addr[1] == base + AW'(4), "R3", "second address", 32'(f_addr[1]), 32'(base + AW'(4)));
         chk(f_be[1] == span[7:4], "R4", "second enables", 32'(f_be[1]), 32'(span[7:4]));
      end
      if (wr) begin
         chk(f_wd[0] == exp_wd, "R5", "lane data first", f_wd[0], exp_wd);
         if (exp_n == 2) chk(f_wd[1] == exp_wd, "R5", "lane data second", f_wd[1], exp_wd);
         chk(done_cyc - last_fire_cyc == 1, "R8", "write done latency",
             32'(done_cyc - last_fire_cyc), 32'd1);
         for (int i = 0; i < s; i++) ref_b[8'(a + AW'(i))] = wd[8*i +: 8];
      end else begin
         chk(rsp_rdata == exp_rd, "R6", "read result", rsp_rdata, exp_rd);
         chk(done_cyc - last_fire_cyc == 2, "R8", "read done latency",
             32'(done_cyc - last_fire_cyc), 32'd2);
      end
      @(negedge clk);
      chk(!rsp_done, "R7", "done single cycle", 32'(rsp_done), 32'd0);
      chk(n_fire == exp_n, "R3", "no extra transaction", 32'(n_fire), 32'(exp_n));
   endtask

   initial begin
      logic [AW-1:0] bases [0:1];
      bases[0] = 16'h0100;
      bases[1] = 16'h01F8;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
      chk(mem_valid == 1'b0, "R1", "reset mem_valid", 32'(mem_valid), 32'd0);
      chk(rsp_done == 1'b0, "R1", "reset done", 32'(rsp_done), 32'd0);
      for (int b = 0; b < 2; b++) begin
         for (int sz = 0; sz < 4; sz++) begin
            for (int o = 0; o < 4; o++) begin
               logic [AW-1:0] a;
               logic [31:0] wd;
               a  = bases[b] + AW'(o) + AW'(4 * sz);
               wd = 32'h1F2E3D4C + 32'(sz) * 32'h01010101 + 32'(o) * 32'h11 + 32'(b) * 32'h5A;
               do_req(1'b1, 2'(sz), a, wd);
               do_req(1'b0, 2'(sz), a, 32'h0);
            end
         end
      end
      // read back whole words over the touched range
      for (int w = 0; w < 8; w++) do_req(1'b0, 2'd2, 16'h0100 + AW'(4 * w), 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R7 watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule